// File: doc/BRIEF.md
# BCD/Binary Real-Time Calendar Counter

This block keeps the time of day and the calendar for a real-time clock: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Once per second a one-cycle pulse on `tick_1s` starts a short update sequence. The sequence moves the time forward by one second and carries into the calendar at midnight. It then compares the new time with three alarm bytes. A single control bit picks packed BCD or plain binary for every byte. A second bit picks the 24-hour form or the 12-hour form with a PM flag.

A host reaches the block through a byte-wide register port. Writes go straight into the counters. Reads return a holding copy that is refreshed only while the sequencer is idle, so a read in the middle of an update returns the previous consistent time. Setting the freeze bit in the control register keeps ticks from advancing the counters while software loads a new time. The sequencer has four states: `ST_IDLE` waits for a tick. `ST_ADV_TIME` steps seconds, minutes and hours. `ST_ADV_DATE` steps the calendar if midnight was crossed. `ST_CHK_ALARM` compares against the alarm bytes. The transitions are IDLE to ADV_TIME (tick while not frozen), ADV_TIME to ADV_DATE, ADV_DATE to CHK_ALARM, and CHK_ALARM to IDLE.

Top module: `rtc_calendar_core`

Register map (4-bit address): 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes, 9 alarm hours, 10 control, 11 flags.

## Requirements
- R1: A `tick_1s` pulse seen in `ST_IDLE` with freeze clear advances the time by one second. Seconds wrap 59 to 0 and carry into minutes, and minutes wrap 59 to 0 and carry into hours. The new value is readable by the fourth clock edge after the tick edge. The sequence visits ADV_TIME, then ADV_DATE, then CHK_ALARM.
- R2: While control bit 0 (freeze) is 1, ticks are ignored and the counters keep their values. Clearing the bit lets the next tick advance the time again.
- R3: Control bit 1 selects the encoding for all bytes: 0 means packed BCD (tens in bits 7:4, units in bits 3:0) and 1 means binary. For example, seconds 09 step to 0x10 in BCD and to 0x0A in binary.
- R4: Day of week steps only at midnight. It counts 1 to 7 and wraps from 7 back to 1.
- R5: At midnight the day of month returns to 1 after the month's last day: 31 days, or 30 for months 4, 6, 9 and 11, or 28 for month 2. Month 2 has 29 days when the binary year value is divisible by 4.
- R6: With control bit 2 clear (12-hour form), hour byte bit 7 is PM and bits 6:0 hold 1 to 12 in the selected encoding. The hour runs 12, 1, ... 11. PM toggles on the step from 11 to 12, and the calendar advances when 11 PM steps to 12 AM.
- R7: With control bit 2 set (24-hour form), hours run 0 to 23, and the step from 23 to 0 advances the calendar.
- R8: If, after an update, seconds, minutes and hours all equal their alarm bytes, the `alarm` output and flags bit 0 are set. A read of the flags register returns the bit and then clears it.
- R9: `rd_data` is registered on the edge where `rd_en` is high. Counter reads return the holding copy, which does not change while an update is in progress.
- R10: The control register reads back {5'b0, hour24, binary, freeze}. After reset it reads 0x04, and the counters read 00:00:00 with day of week 1, 1 January, year 00.
- R11: Month wraps from 12 to 1 and carries into the year, and the year wraps from 99 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Registered host read data |
| alarm | output | 1 | Alarm flag |

## Verification
The assertions check on every cycle that the sequencer starts an update only on a tick taken while not frozen, stays idle under freeze, and steps through its states in order. They also check that the holding copy does not change during an update, that the alarm flag rises only out of the compare state, and that a flag read clears it. Whether the arithmetic is right can only be shown by the bench scenarios. This covers BCD against binary carries, month lengths and the leap day, the 12-hour PM sequence and the year wrap. The bench sweeps every month in both encodings and both hour forms, every hour boundary, and a run of consecutive seconds, and compares the results with a reference model it computes itself.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int VAL_W  = 7;
    localparam int NCNT   = 7;
    localparam int NALM   = 3;

    localparam int C_SEC  = 0;
    localparam int C_MIN  = 1;
    localparam int C_HR   = 2;
    localparam int C_DOW  = 3;
    localparam int C_DATE = 4;
    localparam int C_MON  = 5;
    localparam int C_YR   = 6;

    localparam logic [ADDR_W-1:0] A_ALM0 = ADDR_W'(NCNT);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(NCNT + NALM);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(NCNT + NALM + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADV_TIME,
        ST_ADV_DATE,
        ST_CHK_ALARM
    } seq_state_t;

    // decode a stored byte into its numeric value
    function automatic logic [VAL_W-1:0] to_bin(input logic [BYTE_W-1:0] b,
                                                input logic bin_mode);
        if (bin_mode)
            return b[VAL_W-1:0];
        return VAL_W'({3'b0, b[7:4]} * 7'd10 + {3'b0, b[3:0]});
    endfunction

    // encode a numeric value in the selected format
    function automatic logic [BYTE_W-1:0] from_bin(input logic [VAL_W-1:0] v,
                                                   input logic bin_mode);
        if (bin_mode)
            return {1'b0, v};
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    function automatic logic [VAL_W-1:0] month_days(input logic [VAL_W-1:0] m,
                                                    input logic leap);
        case (m)
            7'd2:                      return leap ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
            default:                   return 7'd31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_time_step.sv
module rtc_time_step
    import rtc_cal_pkg::*;
(
    input  logic [BYTE_W-1:0] sec_i,
    input  logic [BYTE_W-1:0] min_i,
    input  logic [BYTE_W-1:0] hr_i,
    input  logic              bin_mode,
    input  logic              h24,
    output logic [BYTE_W-1:0] sec_o,
    output logic [BYTE_W-1:0] min_o,
    output logic [BYTE_W-1:0] hr_o,
    output logic              day_carry
);
    logic [VAL_W-1:0]  s, m, h, s_n, m_n, h_n;
    logic              carry_m, carry_h, pm, pm_n;
    logic [BYTE_W-1:0] h_enc;

    always_comb begin
        s       = to_bin(sec_i, bin_mode);
        m       = to_bin(min_i, bin_mode);
        carry_m = (s >= 7'd59);
        s_n     = carry_m ? 7'd0 : VAL_W'(s + 7'd1);
        carry_h = carry_m && (m >= 7'd59);
        m_n     = (m >= 7'd59) ? 7'd0 : VAL_W'(m + 7'd1);

        day_carry = 1'b0;
        pm        = hr_i[7];
        pm_n      = pm;
        if (h24) begin
            h   = to_bin(hr_i, bin_mode);
            h_n = h;
            if (h >= 7'd23) begin
                h_n       = 7'd0;
                day_carry = carry_h;
            end else begin
                h_n = VAL_W'(h + 7'd1);
            end
        end else begin
            h = to_bin({1'b0, hr_i[6:0]}, bin_mode);
            if (h == 7'd11) begin
                h_n       = 7'd12;
                pm_n      = ~pm;
                day_carry = carry_h && pm;
            end else if (h >= 7'd12) begin
                h_n = 7'd1;
            end else begin
                h_n = VAL_W'(h + 7'd1);
            end
        end
        h_enc = from_bin(h_n, bin_mode);

        sec_o = from_bin(s_n, bin_mode);
        min_o = carry_m ? from_bin(m_n, bin_mode) : min_i;
        if (!carry_h)
            hr_o = hr_i;
        else if (h24)
            hr_o = h_enc;
        else
            hr_o = {pm_n, h_enc[6:0]};
    end
endmodule

// File: rtl/rtc_date_step.sv
module rtc_date_step
    import rtc_cal_pkg::*;
(
    input  logic [BYTE_W-1:0] dow_i,
    input  logic [BYTE_W-1:0] date_i,
    input  logic [BYTE_W-1:0] mon_i,
    input  logic [BYTE_W-1:0] yr_i,
    input  logic              bin_mode,
    output logic [BYTE_W-1:0] dow_o,
    output logic [BYTE_W-1:0] date_o,
    output logic [BYTE_W-1:0] mon_o,
    output logic [BYTE_W-1:0] yr_o
);
    logic [VAL_W-1:0] dw, d, mo, y, lim;
    logic [VAL_W-1:0] dw_n, d_n, mo_n, y_n;
    logic             leap;

    always_comb begin
        dw   = to_bin(dow_i, bin_mode);
        d    = to_bin(date_i, bin_mode);
        mo   = to_bin(mon_i, bin_mode);
        y    = to_bin(yr_i, bin_mode);
        leap = (y[1:0] == 2'b00);
        lim  = month_days(mo, leap);

        dw_n = (dw >= 7'd7) ? 7'd1 : VAL_W'(dw + 7'd1);
        d_n  = d;
        mo_n = mo;
        y_n  = y;
        if (d >= lim) begin
            d_n = 7'd1;
            if (mo >= 7'd12) begin
                mo_n = 7'd1;
                y_n  = (y >= 7'd99) ? 7'd0 : VAL_W'(y + 7'd1);
            end else begin
                mo_n = VAL_W'(mo + 7'd1);
            end
        end else begin
            d_n = VAL_W'(d + 7'd1);
        end

        dow_o  = from_bin(dw_n, bin_mode);
        date_o = from_bin(d_n, bin_mode);
        mon_o  = (mo_n == mo) ? mon_i : from_bin(mo_n, bin_mode);
        yr_o   = (y_n == y) ? yr_i : from_bin(y_n, bin_mode);
    end
endmodule

// File: rtl/rtc_seq_fsm.sv
module rtc_seq_fsm
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       freeze_i,
    output seq_state_t state_o,
    output logic       load_time_o,
    output logic       load_date_o,
    output logic       check_alarm_o
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d       = state_q;
        load_time_o   = 1'b0;
        load_date_o   = 1'b0;
        check_alarm_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tick_i && !freeze_i)
                    state_d = ST_ADV_TIME;
            end
            ST_ADV_TIME: begin
                load_time_o = 1'b1;
                state_d     = ST_ADV_DATE;
            end
            ST_ADV_DATE: begin
                load_date_o = 1'b1;
                state_d     = ST_CHK_ALARM;
            end
            ST_CHK_ALARM: begin
                check_alarm_o = 1'b1;
                state_d       = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              alarm
);
    logic [BYTE_W-1:0]      cnt_q [NCNT];
    logic [BYTE_W-1:0]      alm_q [NALM];
    logic [NCNT*BYTE_W-1:0] hold_flat;
    logic                   ctl_set, ctl_dm, ctl_h24;
    logic                   alarm_q, day_pend;
    seq_state_t             state;
    logic                   load_time, load_date, check_alarm;
    logic [BYTE_W-1:0]      sec_n, min_n, hr_n, dow_n, date_n, mon_n, yr_n;
    logic                   day_carry, alarm_hit, flag_read;
    logic [BYTE_W-1:0]      rd_mux;

    rtc_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_1s),
        .freeze_i     (ctl_set),
        .state_o      (state),
        .load_time_o  (load_time),
        .load_date_o  (load_date),
        .check_alarm_o(check_alarm)
    );

    rtc_time_step u_time (
        .sec_i    (cnt_q[C_SEC]),
        .min_i    (cnt_q[C_MIN]),
        .hr_i     (cnt_q[C_HR]),
        .bin_mode (ctl_dm),
        .h24      (ctl_h24),
        .sec_o    (sec_n),
        .min_o    (min_n),
        .hr_o     (hr_n),
        .day_carry(day_carry)
    );

    rtc_date_step u_date (
        .dow_i   (cnt_q[C_DOW]),
        .date_i  (cnt_q[C_DATE]),
        .mon_i   (cnt_q[C_MON]),
        .yr_i    (cnt_q[C_YR]),
        .bin_mode(ctl_dm),
        .dow_o   (dow_n),
        .date_o  (date_n),
        .mon_o   (mon_n),
        .yr_o    (yr_n)
    );

    // counters: sequencer updates first, host writes take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCNT; i++)
                cnt_q[i] <= '0;
            cnt_q[C_DOW]  <= 8'd1;
            cnt_q[C_DATE] <= 8'd1;
            cnt_q[C_MON]  <= 8'd1;
            day_pend      <= 1'b0;
        end else begin
            if (load_time) begin
                cnt_q[C_SEC] <= sec_n;
                cnt_q[C_MIN] <= min_n;
                cnt_q[C_HR]  <= hr_n;
                day_pend     <= day_carry;
            end
            if (load_date && day_pend) begin
                cnt_q[C_DOW]  <= dow_n;
                cnt_q[C_DATE] <= date_n;
                cnt_q[C_MON]  <= mon_n;
                cnt_q[C_YR]   <= yr_n;
            end
            if (wr_en && addr < ADDR_W'(NCNT))
                cnt_q[addr[2:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NALM; i++)
                alm_q[i] <= '0;
            ctl_set <= 1'b0;
            ctl_dm  <= 1'b0;
            ctl_h24 <= 1'b1;
        end else if (wr_en) begin
            for (int i = 0; i < NALM; i++)
                if (addr == A_ALM0 + ADDR_W'(i))
                    alm_q[i] <= wr_data;
            if (addr == A_CTL) begin
                ctl_set <= wr_data[0];
                ctl_dm  <= wr_data[1];
                ctl_h24 <= wr_data[2];
            end
        end
    end

    // holding copy per counter, refreshed only between updates
    generate
        for (genvar gi = 0; gi < NCNT; gi++) begin : g_hold
            logic [BYTE_W-1:0] hold_r;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hold_r <= (gi == C_DOW || gi == C_DATE || gi == C_MON) ? 8'd1 : 8'd0;
                else if (state == ST_IDLE)
                    hold_r <= cnt_q[gi];
            end
            assign hold_flat[gi*BYTE_W +: BYTE_W] = hold_r;
        end
    endgenerate

    assign alarm_hit = (cnt_q[C_SEC] == alm_q[0]) &&
                       (cnt_q[C_MIN] == alm_q[1]) &&
                       (cnt_q[C_HR]  == alm_q[2]);
    assign flag_read = rd_en && (addr == A_FLAG);

    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_q <= 1'b0;
        else if (check_alarm && alarm_hit)
            alarm_q <= 1'b1;
        else if (flag_read)
            alarm_q <= 1'b0;
    end

    always_comb begin
        rd_mux = '0;
        if (addr < ADDR_W'(NCNT))
            rd_mux = hold_flat[addr[2:0]*BYTE_W +: BYTE_W];
        else if (addr == A_ALM0)
            rd_mux = alm_q[0];
        else if (addr == A_ALM0 + 4'd1)
            rd_mux = alm_q[1];
        else if (addr == A_ALM0 + 4'd2)
            rd_mux = alm_q[2];
        else if (addr == A_CTL)
            rd_mux = {5'b0, ctl_h24, ctl_dm, ctl_set};
        else if (addr == A_FLAG)
            rd_mux = {7'b0, alarm_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_mux;
    end

    assign alarm = alarm_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1s,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              ctl_set,
    input seq_state_t        state,
    input logic              alarm,
    input logic [BYTE_W-1:0] hold_sec
);
    // R1
    tick_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tick_1s && !ctl_set) |=> (state == ST_ADV_TIME));

    // R1
    seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADV_TIME) |=> (state == ST_ADV_DATE));

    // R2
    freeze_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ctl_set) |=> (state == ST_IDLE));

    // R8
    alarm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> ($past(state) == ST_CHK_ALARM));

    // R8
    alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_FLAG && state != ST_CHK_ALARM) |=> !alarm);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(hold_sec));
endmodule

bind rtc_calendar_core rtc_calendar_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_1s (tick_1s),
    .rd_en   (rd_en),
    .addr    (addr),
    .ctl_set (ctl_set),
    .state   (state),
    .alarm   (alarm),
    .hold_sec(hold_flat[7:0])
);

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1s = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       alarm;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state (hour kept as 0..23)
    int rs, rm, rh, rdow, rd, rmo, ry;

    always #5 clk = ~clk;

    rtc_calendar_core dut (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .alarm(alarm)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(int v, bit dm);
        if (dm) return 8'(v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic logic [7:0] hour_byte(int h, bit dm, bit h24);
        int h12;
        logic [7:0] e;
        if (h24) return enc(h, dm);
        h12 = h % 12;
        if (h12 == 0) h12 = 12;
        e = enc(h12, dm);
        return {(h >= 12) ? 1'b1 : 1'b0, e[6:0]};
    endfunction

    function automatic int mdays(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_step();
        rs++;
        if (rs == 60) begin
            rs = 0; rm++;
            if (rm == 60) begin
                rm = 0; rh++;
                if (rh == 24) begin
                    rh = 0;
                    rdow = (rdow == 7) ? 1 : rdow + 1;
                    rd++;
                    if (rd > mdays(rmo, ry)) begin
                        rd = 1; rmo++;
                        if (rmo == 13) begin
                            rmo = 1;
                            ry = (ry + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic host_wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_rd(logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_1s = 1'b1;
        @(negedge clk);
        tick_1s = 1'b0;
    endtask

    task automatic tick_wait();
        pulse_tick();
        repeat (6) @(negedge clk);
    endtask

    task automatic load_model(bit dm, bit h24);
        host_wr(4'd10, {5'b0, h24, dm, 1'b1});
        host_wr(4'd0, enc(rs, dm));
        host_wr(4'd1, enc(rm, dm));
        host_wr(4'd2, hour_byte(rh, dm, h24));
        host_wr(4'd3, enc(rdow, dm));
        host_wr(4'd4, enc(rd, dm));
        host_wr(4'd5, enc(rmo, dm));
        host_wr(4'd6, enc(ry, dm));
        host_wr(4'd10, {5'b0, h24, dm, 1'b0});
    endtask

    task automatic check_all(bit dm, bit h24);
        logic [7:0] v;
        host_rd(4'd0, v); chk("R1 sec", v, enc(rs, dm));
        host_rd(4'd1, v); chk("R1 min", v, enc(rm, dm));
        host_rd(4'd2, v); chk(h24 ? "R7 hour" : "R6 hour", v, hour_byte(rh, dm, h24));
        host_rd(4'd3, v); chk("R4 dow", v, enc(rdow, dm));
        host_rd(4'd4, v); chk("R5 date", v, enc(rd, dm));
        host_rd(4'd5, v); chk("R11 month", v, enc(rmo, dm));
        host_rd(4'd6, v); chk("R11 year", v, enc(ry, dm));
    endtask

    task automatic run_all();
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        host_rd(4'd0, v);  chk("R10 reset sec", v, 8'h00);
        host_rd(4'd2, v);  chk("R10 reset hour", v, 8'h00);
        host_rd(4'd3, v);  chk("R10 reset dow", v, 8'h01);
        host_rd(4'd4, v);  chk("R10 reset date", v, 8'h01);
        host_rd(4'd5, v);  chk("R10 reset month", v, 8'h01);
        host_rd(4'd10, v); chk("R10 reset ctl", v, 8'h04);
        host_rd(4'd11, v); chk("R10 reset flag", v, 8'h00);
        chk("R10 reset alarm pin", {7'b0, alarm}, 8'h00);

        // R10 control readback
        host_wr(4'd10, 8'h03);
        host_rd(4'd10, v); chk("R10 ctl readback", v, 8'h03);

        // R3 encoding of a units carry
        for (int dm = 0; dm < 2; dm++) begin
            rs = 9; rm = 0; rh = 5; rdow = 2; rd = 3; rmo = 3; ry = 21;
            load_model(dm[0], 1'b1);
            tick_wait();
            host_rd(4'd0, v);
            chk("R3 sec 09 step", v, dm[0] ? 8'h0A : 8'h10);
        end

        // R5 R11 R4 month ends and the day before, all years/modes
        for (int dm = 0; dm < 2; dm++)
            for (int h = 0; h < 2; h++)
                for (int yi = 0; yi < 3; yi++)
                    for (int mo = 1; mo <= 12; mo++)
                        for (int back = 0; back < 2; back++) begin
                            ry = (yi == 0) ? 23 : (yi == 1) ? 24 : 99;
                            rmo = mo; rd = mdays(mo, ry) - back;
                            rdow = (mo % 7) + 1; rh = 23; rm = 59; rs = 59;
                            load_model(dm[0], h[0]);
                            tick_wait();
                            model_step();
                            check_all(dm[0], h[0]);
                        end

        // R6 R7 every hour boundary
        for (int dm = 0; dm < 2; dm++)
            for (int h = 0; h < 2; h++)
                for (int hr = 0; hr < 24; hr++) begin
                    rs = 59; rm = 59; rh = hr; rdow = 7; rd = 30; rmo = 6; ry = 24;
                    load_model(dm[0], h[0]);
                    tick_wait();
                    model_step();
                    check_all(dm[0], h[0]);
                end

        // R1 consecutive seconds across a minute and hour carry
        for (int dm = 0; dm < 2; dm++) begin
            rs = 50; rm = 58; rh = 9; rdow = 4; rd = 10; rmo = 10; ry = 30;
            load_model(dm[0], 1'b1);
            for (int k = 0; k < 80; k++) begin
                tick_wait();
                model_step();
                host_rd(4'd0, v); chk("R1 run sec", v, enc(rs, dm[0]));
                host_rd(4'd1, v); chk("R1 run min", v, enc(rm, dm[0]));
                host_rd(4'd2, v); chk("R1 run hour", v, enc(rh, dm[0]));
            end
        end

        // R9 read during update returns the old value
        rs = 15; rm = 1; rh = 1; rdow = 1; rd = 1; rmo = 1; ry = 1;
        load_model(1'b0, 1'b1);
        pulse_tick();
        host_rd(4'd0, v); chk("R9 held during update", v, 8'h15);
        repeat (6) @(negedge clk);
        host_rd(4'd0, v); chk("R9 after update", v, 8'h16);

        // R2 freeze
        host_wr(4'd10, 8'h05);
        tick_wait();
        tick_wait();
        host_rd(4'd0, v); chk("R2 frozen sec", v, 8'h16);
        host_wr(4'd10, 8'h04);
        tick_wait();
        host_rd(4'd0, v); chk("R2 resumed sec", v, 8'h17);

        // R8 alarm
        rs = 29; rm = 20; rh = 10; rdow = 1; rd = 1; rmo = 1; ry = 1;
        load_model(1'b0, 1'b1);
        host_wr(4'd7, 8'h30);
        host_wr(4'd8, 8'h20);
        host_wr(4'd9, 8'h10);
        tick_wait();
        chk("R8 alarm pin set", {7'b0, alarm}, 8'h01);
        host_rd(4'd11, v); chk("R8 flag read", v, 8'h01);
        host_rd(4'd11, v); chk("R8 flag cleared", v, 8'h00);
        chk("R8 alarm pin cleared", {7'b0, alarm}, 8'h00);
        tick_wait();
        chk("R8 no match", {7'b0, alarm}, 8'h00);
    endtask

    initial begin
        run_all();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule